// File: doc/BRIEF.md
# Event-Triggered Timestamp Capture Counter

This block runs a 40-bit free-running counter and, when a chosen external event arrives, copies the counter value into a capture register. The host computes elapsed time by subtracting two successive captures. Events can come from any one of several general-purpose input lines, on either edge. They can also come from a chip-select line, where only its high-to-low transition counts. Every event line is asynchronous to the counter clock, so each one passes through a synchronizer and an edge detector before it can trigger a capture.

After a capture, the block stays locked and ignores new events until the host reads the lowest byte of the captured value. That read re-arms the block. The host reads the captured value one byte at a time through a small registered read port. The upper bytes should be read before the lowest one, because the lowest-byte read is what lets a new event overwrite the value. The counter advances only in cycles where a count-enable input is high, which models a slower counting clock derived from the system clock.

Top module: `evstamp_top`

## Requirements
- R1: The counter is CNT_W bits wide (40 by default), is zero after reset, and advances by one on each clock edge where `cnt_en` is high. It holds its value on each clock edge where `cnt_en` is low.
- R2: When the counter holds all ones and `cnt_en` is high, the next value is zero.
- R3: `src_sel` chooses the event source. A value i below NUM_GPIO (8 by default) selects `gpio_in[i]`. The value NUM_GPIO selects `cs_n`. Any larger value selects nothing. Lines that are not selected never cause a capture.
- R4: For a general-purpose source i, the active edge is the rising edge when `pol_inv[i]` is 0 and the falling edge when `pol_inv[i]` is 1. The opposite edge is ignored.
- R5: When `cs_n` is the source, only its high-to-low transition is an event. Its low-to-high transition is ignored.
- R6: Each event line passes through a two-flop synchronizer and an edge detector. If a line changes before clock edge k, the capture occurs at edge k+2. The value captured is the counter value held just before edge k+2.
- R7: A capture sets `capture_pending`. While it is set, events do not change the capture register.
- R8: A read of address 0 clears `capture_pending` and re-arms the block. Reads of addresses 1 to 4 leave the lock and the pending flag unchanged.
- R9: A read is a cycle with `rd_en` high. One cycle later, `rd_data` holds the result. Addresses 0 to 4 return capture bytes, with address 0 the least significant byte and address 4 the most significant. Address 7 returns `{7'b0, capture_pending}`. Addresses 5 and 6 return zero.
- R10: If a read of address 0 and an event occur in the same cycle, the read returns the old byte, the event produces a new capture, and `capture_pending` stays set.
- R11: Reset clears the counter, the capture register and `capture_pending`, and leaves the block armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; the counter advances in cycles where it is high |
| gpio_in | input | NUM_GPIO | Asynchronous general-purpose event lines |
| pol_inv | input | NUM_GPIO | Per-line edge select: 0 selects rising, 1 selects falling |
| cs_n | input | 1 | Asynchronous chip-select line; its falling edge is an event |
| src_sel | input | clog2(NUM_GPIO+1) | Event source select |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| capture_pending | output | 1 | A capture is waiting to be read |

## Verification
The assertions assume that the event lines come from outside the clock domain and that their only effect is through the synchronized edge pulses. They also assume that `src_sel` and `pol_inv` stay steady while an edge pulse is travelling through a synchronizer. The stimulus drives every input half a cycle away from the active edge. It changes the source and polarity settings only while all lines are quiet. Every pin change is held for several cycles, so each edge yields exactly one pulse. The counter wrap is exercised on a second instance with a 10-bit counter, which reaches all ones within about a thousand cycles.

// File: rtl/evstamp_pkg.sv
package evstamp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_GPIO = 2'd1,
    SRC_CS   = 2'd2
  } src_kind_e;
endpackage

// File: rtl/evstamp_edge.sv
// Synchronizer chain plus edge detector for one asynchronous event line.
module evstamp_edge #(
  parameter int STAGES  = 2,
  parameter bit RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {STAGES{RST_LVL}};
      last_q <= RST_LVL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;

  // R6: an edge pulse lasts a single cycle
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  assert_fall_single_R6: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/evstamp_ctr.sv
// Free-running counter with count enable.
module evstamp_ctr #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + W'(1);
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != '1) |=> cnt == $past(cnt) + W'(1));
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/evstamp_cap.sv
// Capture register with lock and re-arm.
module evstamp_cap #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic         rearm,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap,
  output logic         pending
);
  logic fire;

  // A re-arming read in the same cycle frees the lock for this event.
  assign fire = ev && (!pending || rearm);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap     <= '0;
      pending <= 1'b0;
    end else begin
      if (fire) cap <= cnt;
      if (fire)       pending <= 1'b1;
      else if (rearm) pending <= 1'b0;
    end
  end

  assert_take_R6: assert property (@(posedge clk) disable iff (rst)
    (ev && !pending) |=> (cap == $past(cnt) && pending));
  assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (pending && !rearm) |=> ($stable(cap) && pending));
  assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (rearm && !ev) |=> !pending);
  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (rearm && ev) |=> (pending && cap == $past(cnt)));
endmodule

// File: rtl/evstamp_rd.sv
// Registered byte-wide read port over the capture register.
module evstamp_rd
  import evstamp_pkg::*;
#(
  parameter int W      = 40,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [W-1:0]      cap,
  input  logic              pending,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rearm
);
  localparam int NB = (W + BYTE_W - 1) / BYTE_W;
  localparam logic [ADDR_W-1:0] STAT_ADDR = '1;

  logic [NB*BYTE_W-1:0] padded;
  logic [BYTE_W-1:0]    rd_next;

  always_comb begin
    padded         = '0;
    padded[W-1:0]  = cap;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NB; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_next = padded[k*BYTE_W +: BYTE_W];
    end
    if (rd_addr == STAT_ADDR) rd_next = {{(BYTE_W-1){1'b0}}, pending};
  end

  assign rearm = rd_en && (rd_addr == '0);

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assert_low_byte_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == '0) |=> rd_data == $past(cap[BYTE_W-1:0]));
  assert_status_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == STAT_ADDR) |=> rd_data == {{(BYTE_W-1){1'b0}}, $past(pending)});
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/evstamp_top.sv
// Event-triggered timestamp capture counter.
module evstamp_top
  import evstamp_pkg::*;
#(
  parameter int CNT_W    = 40,
  parameter int NUM_GPIO = 8,
  parameter int SYNC_STG = 2,
  parameter int ADDR_W   = 3,
  localparam int SEL_W   = $clog2(NUM_GPIO + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_en,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [NUM_GPIO-1:0] pol_inv,
  input  logic                cs_n,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                capture_pending
);
  logic [NUM_GPIO-1:0] g_rise, g_fall;
  logic                cs_rise, cs_fall;
  logic [CNT_W-1:0]    cnt, cap;
  logic                ev, rearm;
  src_kind_e           kind;

  for (genvar i = 0; i < NUM_GPIO; i++) begin : g_line
    evstamp_edge #(.STAGES(SYNC_STG), .RST_LVL(1'b0)) u_edge (
      .clk (clk), .rst (rst), .din (gpio_in[i]),
      .rise(g_rise[i]), .fall(g_fall[i])
    );
  end

  evstamp_edge #(.STAGES(SYNC_STG), .RST_LVL(1'b1)) u_cs_edge (
    .clk (clk), .rst (rst), .din (cs_n),
    .rise(cs_rise), .fall(cs_fall)
  );

  always_comb begin
    if (src_sel < SEL_W'(NUM_GPIO))       kind = SRC_GPIO;
    else if (src_sel == SEL_W'(NUM_GPIO)) kind = SRC_CS;
    else                                  kind = SRC_NONE;
  end

  always_comb begin
    ev = 1'b0;
    unique case (kind)
      SRC_GPIO: begin
        for (int i = 0; i < NUM_GPIO; i++) begin
          if (src_sel == SEL_W'(i)) ev = pol_inv[i] ? g_fall[i] : g_rise[i];
        end
      end
      SRC_CS:   ev = cs_fall;
      default:  ev = 1'b0;
    endcase
  end

  evstamp_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt)
  );

  evstamp_cap #(.W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .ev(ev), .rearm(rearm), .cnt(cnt),
    .cap(cap), .pending(capture_pending)
  );

  evstamp_rd #(.W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .cap(cap),
    .pending(capture_pending), .rd_data(rd_data), .rearm(rearm)
  );

  // R5: a rising chip-select edge alone never starts a capture
  assert_cs_rise_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == SRC_CS && cs_rise && !capture_pending) |=> !capture_pending);
  // R3: nothing is captured while no source is selected
  assert_no_source_R3: assert property (@(posedge clk) disable iff (rst)
    (kind == SRC_NONE && !capture_pending) |=> !capture_pending);
endmodule

// File: tb/sim_evstamp_top.sv
module sim_evstamp_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_en = 1'b0;
  logic [NG-1:0] gpio = '0;
  logic [NG-1:0] pol = '0;
  logic          cs_n = 1'b1;
  logic [SW-1:0] sel = '0;
  logic          rd_en = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic [7:0]    rd0, rd1;
  logic          pend0, pend1;
  logic [39:0]   ref_cnt;
  int            n_chk = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference count from R1/R11
  always @(posedge clk) begin
    if (rst)         ref_cnt <= '0;
    else if (cnt_en) ref_cnt <= ref_cnt + 40'd1;
  end

  evstamp_top u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gpio_in(gpio), .pol_inv(pol),
    .cs_n(cs_n), .src_sel(sel), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd0), .capture_pending(pend0)
  );

  evstamp_top #(.CNT_W(10)) u1 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gpio_in(gpio), .pol_inv(pol),
    .cs_n(cs_n), .src_sel(sel), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd1), .capture_pending(pend1)
  );

  task automatic chk(input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] d0, output logic [7:0] d1);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d0 = rd0; d1 = rd1;
  endtask

  task automatic read_cap(output logic [39:0] v);
    logic [7:0] d0, d1;
    v = '0;
    for (int b = 4; b >= 0; b--) begin
      rd_byte(3'(b), d0, d1);
      v[b*8 +: 8] = d0;
    end
  endtask

  // Caller changed a pin at the current negedge; returns the expected capture.
  task automatic wait_capture(output logic [39:0] exp);
    @(negedge clk);
    @(negedge clk); exp = ref_cnt;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [39:0] v; logic [7:0] d0, d1;
    chk("R11", "pending after reset", 40'(pend0), 40'd0);
    read_cap(v);
    chk("R11", "capture after reset", v, 40'd0);
    rd_byte(3'd7, d0, d1);
    chk("R11", "status after reset", 40'(d0), 40'd0);
  endtask

  task automatic t_wrap();
    logic [39:0] exp, v; logic [7:0] d0, d1, h0, h1;
    cnt_en = 1'b1;
    repeat (1100) @(negedge clk);
    sel = 4'd0; gpio[0] = 1'b1;
    wait_capture(exp);
    chk("R7", "pending after capture", 40'(pend0), 40'd1);
    rd_byte(3'd1, h0, h1);
    rd_byte(3'd0, d0, d1);
    chk("R2", "wrapped narrow capture", 40'({h1[1:0], d1}), 40'(exp[9:0]));
    chk("R2", "narrow count wrapped", 40'(exp > 40'd1023), 40'd1);
    chk("R6", "wide capture low byte", 40'(d0), 40'(exp[7:0]));
    read_cap(v);
    chk("R6", "wide capture", v, exp);
  endtask

  task automatic t_falling_ignored();
    @(negedge clk); gpio[0] = 1'b0;
    settle();
    chk("R4", "falling edge with pol 0 ignored", 40'(pend0), 40'd0);
  endtask

  task automatic t_hold();
    logic [39:0] exp, v;
    @(negedge clk); cnt_en = 1'b0;
    repeat (40) @(negedge clk);
    gpio[0] = 1'b1;
    wait_capture(exp);
    cnt_en = 1'b1;
    read_cap(v);
    chk("R1", "capture with count held", v, exp);
    @(negedge clk); gpio[0] = 1'b0;
    settle();
  endtask

  task automatic t_select();
    logic [39:0] exp, v;
    @(negedge clk); sel = 4'd2; gpio[3] = 1'b1;
    settle();
    chk("R3", "unselected line ignored", 40'(pend0), 40'd0);
    gpio[3] = 1'b0;
    settle();
    gpio[2] = 1'b1;
    wait_capture(exp);
    read_cap(v);
    chk("R3", "selected line capture", v, exp);
    @(negedge clk); gpio[2] = 1'b0;
    settle();
    sel = 4'd12; gpio[0] = 1'b1;
    settle();
    chk("R3", "out-of-range select ignored", 40'(pend0), 40'd0);
    gpio[0] = 1'b0;
    settle();
  endtask

  task automatic t_pol();
    logic [39:0] exp, v;
    @(negedge clk); sel = 4'd5; pol[5] = 1'b1;
    settle();
    gpio[5] = 1'b1;
    settle();
    chk("R4", "rising edge with pol 1 ignored", 40'(pend0), 40'd0);
    gpio[5] = 1'b0;
    wait_capture(exp);
    read_cap(v);
    chk("R4", "falling edge with pol 1 capture", v, exp);
  endtask

  task automatic t_cs();
    logic [39:0] exp, v;
    @(negedge clk); sel = 4'd8;
    settle();
    cs_n = 1'b0;
    wait_capture(exp);
    read_cap(v);
    chk("R5", "chip-select fall capture", v, exp);
    @(negedge clk); cs_n = 1'b1;
    settle();
    chk("R5", "chip-select rise ignored", 40'(pend0), 40'd0);
  endtask

  task automatic t_lock();
    logic [39:0] exp, v; logic [7:0] d0, d1;
    @(negedge clk); sel = 4'd0;
    settle();
    gpio[0] = 1'b1;
    wait_capture(exp);
    gpio[0] = 1'b0;
    settle();
    gpio[0] = 1'b1;
    settle();
    chk("R7", "pending while locked", 40'(pend0), 40'd1);
    for (int b = 4; b >= 1; b--) begin
      rd_byte(3'(b), d0, d1);
      chk("R7", "locked byte", 40'(d0), 40'(exp[b*8 +: 8]));
    end
    chk("R8", "upper reads keep pending", 40'(pend0), 40'd1);
    rd_byte(3'd7, d0, d1);
    chk("R9", "status shows pending", 40'(d0), 40'd1);
    rd_byte(3'd0, d0, d1);
    chk("R7", "locked low byte", 40'(d0), 40'(exp[7:0]));
    chk("R8", "low byte read clears pending", 40'(pend0), 40'd0);
    rd_byte(3'd5, d0, d1);
    chk("R9", "address 5 reads zero", 40'(d0), 40'd0);
    rd_byte(3'd6, d0, d1);
    chk("R9", "address 6 reads zero", 40'(d0), 40'd0);
  endtask

  task automatic t_same_cycle();
    logic [39:0] exp1, exp2, v;
    @(negedge clk); gpio[0] = 1'b0;
    settle();
    gpio[0] = 1'b1;
    wait_capture(exp1);
    gpio[0] = 1'b0;
    settle();
    gpio[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); exp2 = ref_cnt; rd_en = 1'b1; rd_addr = 3'd0;
    @(negedge clk); rd_en = 1'b0;
    chk("R10", "read returns old low byte", 40'(rd0), 40'(exp1[7:0]));
    chk("R10", "pending stays set", 40'(pend0), 40'd1);
    read_cap(v);
    chk("R10", "new capture taken", v, exp2);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_falling_ignored();
    t_hold();
    t_select();
    t_pol();
    t_cs();
    t_lock();
    t_same_cycle();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule